// File: doc/BRIEF.md
# Level and Edge Trigger Matcher

This block decides when a logic-analyser style capture has found its trigger. Every sample presented with the sample-enable strobe is tested against a per-channel configuration. Each channel carries three bits: a mask bit, a value bit and an edge bit. Together they ask for a high level, a low level, a rising edge or a falling edge on that channel, or they leave the channel out. Two extra mask bits, above the channel bits, ask for a rising or a falling edge on an asynchronous external trigger line. That line is brought into the clock domain before it is used.

The matcher is armed by a one-cycle `arm` pulse. After that, the first accepted sample that meets every requested condition fires a single `hit` pulse and sets a `triggered` flag. The flag stays set until the next arm. Only one trigger stage exists. Once triggered, the matcher ignores further samples until it is armed again. Edges are judged between two consecutive accepted samples, so edge conditions cannot be met by the first sample after arming.

Top module: `trig_matcher`

## Requirements
- R1: After reset `hit` and `triggered` are 0. Until the first `arm` pulse, no sample can raise either output, even with an all-zero mask.
- R2: A channel i (0 <= i < NUM_CH) whose mask bit `cfgMask[i]` is 0 has no effect on the match, whatever its data, value and edge bits.
- R3: For a channel with `cfgMask[i]`=1 and `cfgEdge[i]`=0, the condition holds when `sampleData[i]` equals `cfgValue[i]` (1 asks for high, 0 asks for low).
- R4: For a channel with `cfgMask[i]`=1 and `cfgEdge[i]`=1, `cfgValue[i]`=1 asks for a rising edge and `cfgValue[i]`=0 asks for a falling edge. The edge is judged against the previous accepted sample of that channel.
- R5: `cfgMask[NUM_CH+1]`=1 asks for a rising edge and `cfgMask[NUM_CH]`=1 asks for a falling edge of `extTrig`. The line passes through a two-flop synchroniser and is compared between consecutive accepted samples. With both bits set, the external condition can never hold.
- R6: A hit needs every requested condition to hold on the same accepted sample. `hit` is high in the clock cycle after the clock edge that accepts that sample.
- R7: On the first accepted sample after an arm, no channel edge condition and no external edge condition can hold.
- R8: With the whole mask at zero, the first accepted sample after an arm produces a hit.
- R9: `hit` lasts exactly one clock cycle. `triggered` stays 1 until the next `arm`. After a hit, no further hit occurs until the matcher is re-armed.
- R10: `arm` clears `triggered` and restarts edge history. A `sampleEn` in the same cycle as `arm` is not accepted.
- R11: Data presented while `sampleEn` is 0 is not accepted and does not replace the previous sample used for edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-cycle pulse that (re)arms the matcher |
| sampleEn | input | 1 | Marks `sampleData` as a valid sample this cycle |
| sampleData | input | NUM_CH | Channel sample |
| extTrig | input | 1 | Asynchronous external trigger line |
| cfgMask | input | NUM_CH+2 | Channel enables, plus external falling (bit NUM_CH) and rising (bit NUM_CH+1) enables |
| cfgValue | input | NUM_CH | Required level or edge direction per channel |
| cfgEdge | input | NUM_CH | 1 selects edge matching, 0 selects level matching |
| hit | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky trigger flag, cleared by `arm` |

## Verification
A stale or wrongly updated previous-sample register produces a spurious or missing `hit` exactly one cycle after the next accepted sample that depends on an edge condition. A wrong control state shows as a second `hit` after triggering, as a hit before arming, or as `triggered` dropping without an arm, each visible in the cycle after the offending edge. A wrong synchroniser depth shifts an external-edge hit by a sample, so the bench lets the line settle for three clocks after each change and then checks the very next accepted sample.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;

  // Strobes the control path hands to the datapath each cycle
  typedef struct packed {
    logic flush;      // arm seen: restart history
    logic load;       // sample accepted this cycle
    logic edgeValid;  // a previous accepted sample exists
  } trigStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } trigState_t;

endpackage

// File: rtl/trig_ext_sync.sv
module trig_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/trig_match_dp.sv
module trig_match_dp
  import trig_match_pkg::*;
#(
  parameter int NUM_CH = 34,
  localparam int MASK_W = NUM_CH + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  trigStrobe_t       strobe,
  input  logic [NUM_CH-1:0] sampleData,
  input  logic              extLevel,
  input  logic [MASK_W-1:0] cfgMask,
  input  logic [NUM_CH-1:0] cfgValue,
  input  logic [NUM_CH-1:0] cfgEdge,
  output logic              matchAll
);
  localparam int EXT_FALL_BIT = NUM_CH;
  localparam int EXT_RISE_BIT = NUM_CH + 1;

  logic [NUM_CH-1:0] prevSample;
  logic              prevExt;
  logic [NUM_CH-1:0] chanOk;
  logic              extRiseOk;
  logic              extFallOk;

  // History moves only on accepted samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '0;
      prevExt    <= 1'b0;
    end else if (strobe.load) begin
      prevSample <= sampleData;
      prevExt    <= extLevel;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      logic curBit, oldBit, rose, fell, levelOk, edgeOk;
      always_comb begin
        curBit  = sampleData[i];
        oldBit  = prevSample[i];
        rose    = strobe.edgeValid & ~oldBit &  curBit;
        fell    = strobe.edgeValid &  oldBit & ~curBit;
        levelOk = (curBit == cfgValue[i]);
        edgeOk  = cfgValue[i] ? rose : fell;
        chanOk[i] = ~cfgMask[i] | (cfgEdge[i] ? edgeOk : levelOk);
      end
    end
  endgenerate

  always_comb begin
    extRiseOk = ~cfgMask[EXT_RISE_BIT] | (strobe.edgeValid & ~prevExt &  extLevel);
    extFallOk = ~cfgMask[EXT_FALL_BIT] | (strobe.edgeValid &  prevExt & ~extLevel);
    matchAll  = (&chanOk) & extRiseOk & extFallOk;
  end

  AST_FIRST_NO_CHAN_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.edgeValid && |(cfgMask[NUM_CH-1:0] & cfgEdge)) |-> !matchAll) // R7
    else $error("edge channel matched on first sample");

  AST_EXT_BOTH_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMask[EXT_RISE_BIT] && cfgMask[EXT_FALL_BIT]) |-> !matchAll) // R5
    else $error("external rise and fall both matched");

  AST_HISTORY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(prevSample) && $stable(prevExt)) // R11
    else $error("history changed without accepted sample");
endmodule

// File: rtl/trig_match_ctrl.sv
module trig_match_ctrl
  import trig_match_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        arm,
  input  logic        sampleEn,
  input  logic        matchAll,
  output trigStrobe_t strobe,
  output logic        hit,
  output logic        triggered
);
  trigState_t state, stateNext;
  logic       accept;
  logic       fire;

  always_comb begin
    accept    = sampleEn && !arm && (state == ST_FIRST || state == ST_RUN);
    fire      = accept && matchAll;
    stateNext = state;
    if (arm)         stateNext = ST_FIRST;
    else if (fire)   stateNext = ST_DONE;
    else if (accept) stateNext = ST_RUN;
    strobe.flush     = arm;
    strobe.load      = accept;
    strobe.edgeValid = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hit       <= 1'b0;
      triggered <= 1'b0;
    end else begin
      state <= stateNext;
      hit   <= fire;
      if (arm)       triggered <= 1'b0;
      else if (fire) triggered <= 1'b1;
    end
  end

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> !hit) // R9
    else $error("hit longer than one cycle");

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> triggered) // R6
    else $error("hit without triggered");

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (triggered && !arm) |=> triggered) // R9
    else $error("triggered dropped without arm");

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (!triggered && !hit)) // R10
    else $error("arm did not clear");

  AST_HIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $past(sampleEn)) // R6
    else $error("hit without sample");

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!hit && !triggered)) // R1
    else $error("activity before arm");
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
  import trig_match_pkg::*;
#(
  parameter int NUM_CH      = 34,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                arm,
  input  logic                sampleEn,
  input  logic [NUM_CH-1:0]   sampleData,
  input  logic                extTrig,
  input  logic [NUM_CH+1:0]   cfgMask,
  input  logic [NUM_CH-1:0]   cfgValue,
  input  logic [NUM_CH-1:0]   cfgEdge,
  output logic                hit,
  output logic                triggered
);
  trigStrobe_t strobe;
  logic        extLevel;
  logic        matchAll;

  trig_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(extTrig), .syncOut(extLevel)
  );

  trig_match_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleData(sampleData),
    .extLevel(extLevel), .cfgMask(cfgMask), .cfgValue(cfgValue),
    .cfgEdge(cfgEdge), .matchAll(matchAll)
  );

  trig_match_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .sampleEn(sampleEn),
    .matchAll(matchAll), .strobe(strobe), .hit(hit), .triggered(triggered)
  );
endmodule

// File: tb/trig_matcher_tb.sv
module trig_matcher_tb;
  localparam int NCH = 34;
  localparam int CLK_PERIOD = 10;
  localparam int RISE_BIT = NCH + 1;
  localparam int FALL_BIT = NCH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arm = 1'b0;
  logic sampleEn = 1'b0;
  logic [NCH-1:0] sampleData = '0;
  logic extTrig = 1'b0;
  logic [NCH+1:0] cfgMask = '0;
  logic [NCH-1:0] cfgValue = '0;
  logic [NCH-1:0] cfgEdge = '0;
  logic hit, triggered;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  // reference model state
  bit mArmed = 0, mTrig = 0, mFirst = 1, mPrevExt = 0;
  logic [NCH-1:0] mPrev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_matcher #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rstN(rstN), .arm(arm), .sampleEn(sampleEn),
    .sampleData(sampleData), .extTrig(extTrig), .cfgMask(cfgMask),
    .cfgValue(cfgValue), .cfgEdge(cfgEdge), .hit(hit), .triggered(triggered)
  );

  function automatic bit modelMatch(logic [NCH-1:0] d, bit ext);
    bit ok = 1;
    for (int i = 0; i < NCH; i++) begin
      if (cfgMask[i]) begin
        if (!cfgEdge[i]) ok &= (d[i] == cfgValue[i]);
        else if (mFirst) ok = 0;
        else if (cfgValue[i]) ok &= (!mPrev[i] && d[i]);
        else ok &= (mPrev[i] && !d[i]);
      end
    end
    if (cfgMask[RISE_BIT]) ok &= (!mFirst && !mPrevExt && ext);
    if (cfgMask[FALL_BIT]) ok &= (!mFirst && mPrevExt && !ext);
    return ok;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic settleExt(bit v);
    if (extTrig != v) begin
      extTrig = v;
      repeat (3) begin @(posedge clk); @(negedge clk); end
    end
  endtask

  // one cycle with optional accepted sample; checks both outputs after
  task automatic doSample(string req, logic [NCH-1:0] d, bit en, bit ext);
    bit expHit;
    settleExt(ext);
    expHit = en && mArmed && !mTrig && modelMatch(d, ext);
    sampleData = d;
    sampleEn = en;
    @(posedge clk);
    @(negedge clk);
    sampleEn = 1'b0;
    if (en && mArmed && !mTrig) begin
      mPrev = d; mPrevExt = ext; mFirst = 0;
      if (expHit) mTrig = 1;
    end
    chk(req, "hit", hit, expHit);
    chk(req, "triggered", triggered, mTrig);
  endtask

  task automatic doArm(string req, bit withSample);
    arm = 1'b1;
    sampleEn = withSample;
    sampleData = '1;
    @(posedge clk);
    @(negedge clk);
    arm = 1'b0;
    sampleEn = 1'b0;
    mArmed = 1; mTrig = 0; mFirst = 1;
    chk(req, "hit", hit, 1'b0);
    chk(req, "triggered", triggered, 1'b0);
  endtask

  task automatic setCfg(logic [NCH+1:0] m, logic [NCH-1:0] v, logic [NCH-1:0] e);
    cfgMask = m; cfgValue = v; cfgEdge = e;
  endtask

  function automatic logic [NCH-1:0] rnd();
    return NCH'({$urandom(), $urandom()});
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "hit", hit, 1'b0);
    chk("R1", "triggered", triggered, 1'b0);
    // R1: not armed, empty mask, no hit
    setCfg('0, '0, '0);
    doSample("R1", rnd(), 1, 0);

    // R8 all-zero mask fires on first sample; R9 single shot and sticky
    doArm("R10", 0);
    doSample("R8", rnd(), 1, 0);
    doSample("R9", rnd(), 1, 0);
    doSample("R9", rnd(), 1, 0);

    // R10: arm with simultaneous sample is not accepted
    doArm("R10", 1);
    doSample("R10", rnd(), 1, 0);

    // R3 level high on channel 3, R2 other channels ignored
    setCfg(36'h8, 34'h8, '0);
    doArm("R10", 0);
    doSample("R2", 34'h3_FFFF_FFF7, 1, 0);
    doSample("R3", 34'h0000_0008, 1, 0);
    // level low
    setCfg(36'h8, '0, '0);
    doArm("R10", 0);
    doSample("R3", 34'h8, 1, 0);
    doSample("R3", 34'h3_FFFF_FFF7, 1, 0);

    // R7 rising on channel 5 not on first sample; R4 rising later
    setCfg(36'h20, 34'h20, 34'h20);
    doArm("R10", 0);
    doSample("R7", 34'h20, 1, 0);
    doSample("R4", 34'h0, 1, 0);
    doSample("R4", 34'h20, 1, 0);
    // falling
    setCfg(36'h20, '0, 34'h20);
    doArm("R10", 0);
    doSample("R7", 34'h0, 1, 0);
    doSample("R4", 34'h20, 1, 0);
    doSample("R4", 34'h20, 1, 0);
    doSample("R4", 34'h0, 1, 0);

    // R11: unaccepted data does not replace history
    setCfg(36'h20, 34'h20, 34'h20);
    doArm("R10", 0);
    doSample("R11", 34'h0, 1, 0);
    doSample("R11", 34'h20, 0, 0);
    doSample("R11", 34'h20, 1, 0);

    // R5 external rising, falling, both
    setCfg(36'h1 << RISE_BIT, '0, '0);
    doArm("R10", 0);
    doSample("R7", '0, 1, 1);
    doSample("R5", '0, 1, 0);
    doSample("R5", '0, 1, 1);
    setCfg(36'h1 << FALL_BIT, '0, '0);
    doArm("R10", 0);
    doSample("R5", '0, 1, 1);
    doSample("R5", '0, 1, 0);
    setCfg(36'h3 << FALL_BIT, '0, '0);
    doArm("R10", 0);
    doSample("R5", '0, 1, 0);
    doSample("R5", '0, 1, 1);
    doSample("R5", '0, 1, 0);

    // R6 AND of level ch1 high and rising ch2
    setCfg(36'h6, 34'h6, 34'h4);
    doArm("R10", 0);
    doSample("R6", 34'h0, 1, 0);
    doSample("R6", 34'h4, 1, 0);
    doSample("R6", 34'h2, 1, 0);
    doSample("R6", 34'h6, 1, 0);

    // random mix
    for (int a = 0; a < 300; a++) begin
      logic [NCH+1:0] m = '0;
      int nb = $urandom_range(0, 3);
      for (int k = 0; k < nb; k++) m[$urandom_range(0, NCH+1)] = 1'b1;
      setCfg(m, rnd(), rnd());
      doArm("R10", $urandom_range(0, 3) == 0);
      for (int s = 0; s < 20; s++) begin
        logic [NCH-1:0] d = rnd() & ~rnd();
        bit ext = ($urandom_range(0, 5) == 0) ? ~extTrig : extTrig;
        doSample("R6", d, $urandom_range(0, 3) != 0, ext);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule